// File: doc/BRIEF.md
# Privilege-Aware Interrupt Threshold Gate

This block sits beside a core-local interrupt controller. It decides whether the single winning pending interrupt may be taken by the hart. The controller presents the interrupt's identifier, its target privilege mode and its 8-bit level. The gate compares these with the hart's current privilege mode, a per-mode level threshold and the per-mode global enables. From that comparison it raises a registered take request.

The same logic also serves the software "next interrupt" CSR read. A handler polls this read to find further interrupts worth servicing without leaving and re-entering. The read compares the pending level with the previous-interrupt level stored for the mode and with the mode's threshold. On a hit it returns the identifier and records the new level as the previous level.

The threshold of a mode only masks interrupts while the hart runs in that mode. Interrupts aimed at a more privileged mode pass regardless of that mode's threshold. Interrupts aimed at a less privileged mode never pass. A return instruction that drops to a lower mode clears the threshold of the mode being left, so a stale threshold cannot silently hold off polled interrupts after the next trap. The previous-privilege fields that decide whether a return lowers privilege are kept here as well.

Top module: `irq_thresh_gate`

## Requirements
- R1: After reset, both thresholds, both previous levels, the M previous-privilege field and the S previous-privilege bit are zero. The take request, the taken identifier and the next-interrupt outputs are zero.
- R2: Privilege codes are U=2'b00, S=2'b01 and M=2'b11. An interrupt whose target code is numerically below the current mode is never taken. An interrupt targeting U or the reserved code 2'b10 is never taken.
- R3: An interrupt targeting a mode above the current one is taken whatever that mode's threshold holds, provided the target's global enable is set.
- R4: An interrupt targeting the current mode (M or S) is taken only when its level is strictly greater than that mode's threshold.
- R5: take_req and take_id are registered: they reflect the inputs of the previous cycle. take_req stays low when the global enable of the target mode (gie_m for M, gie_s for S) was clear. take_id is zero whenever take_req is low.
- R6: With nxt_rd high, nxt_valid is high and nxt_id equals irq_id in the same cycle only when all of these hold: irq_valid is high, the target equals the current mode (M or S), and the level is strictly greater than both that mode's previous level and its threshold. Otherwise nxt_valid and nxt_id are zero.
- R7: On a next-interrupt hit, that mode's previous level becomes the interrupt's level at the next clock edge. This takes precedence over a CSR write to the same field.
- R8: An MRET (ret_valid with ret_mret=1) is honoured only when the current mode is M. It always sets the M previous-privilege field to U. It clears the M threshold when that field was not M before the return.
- R9: An SRET (ret_valid with ret_mret=0) is honoured only when the current mode is S. It always clears the S previous-privilege bit (1=S, 0=U). It clears the S threshold when that bit was 0 before the return.
- R10: A return that does not lower privilege, such as an MRET with the M previous-privilege field at M, leaves the threshold unchanged.
- R11: CSR writes use csr_sel=0 for a threshold, 1 for a previous level and 2 for the previous-privilege field, and csr_mode=1 for M or 0 for S. A return's clear takes precedence over a same-cycle threshold write. A return's previous-privilege reset takes precedence over a same-cycle field write. Writing 2'b10 to the M field stores U.
- R12: A return instruction not matching the current mode (an MRET outside M, or an SRET outside S) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_priv | input | 2 | Current hart privilege mode |
| gie_m | input | 1 | Global interrupt enable for M-mode targets |
| gie_s | input | 1 | Global interrupt enable for S-mode targets |
| irq_valid | input | 1 | A winning interrupt is pending |
| irq_priv | input | 2 | Target privilege mode of the winning interrupt |
| irq_level | input | LVL_W | Level of the winning interrupt |
| irq_id | input | ID_W | Identifier of the winning interrupt (nonzero) |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 2 | CSR field select: threshold, previous level, previous privilege |
| csr_mode | input | 1 | Mode of the CSR field written (1=M, 0=S) |
| csr_wdata | input | LVL_W | CSR write data |
| ret_valid | input | 1 | A return instruction retires this cycle |
| ret_mret | input | 1 | The return is MRET (1) or SRET (0) |
| nxt_rd | input | 1 | Software next-interrupt read this cycle |
| take_req | output | 1 | Registered request to take the interrupt |
| take_id | output | ID_W | Identifier of the interrupt being requested |
| nxt_valid | output | 1 | Next-interrupt read found a qualifying interrupt |
| nxt_id | output | ID_W | Next-interrupt read result, zero when none |
| thresh_m | output | LVL_W | M-mode threshold |
| thresh_s | output | LVL_W | S-mode threshold |
| pil_m | output | LVL_W | M-mode previous interrupt level |
| pil_s | output | LVL_W | S-mode previous interrupt level |
| mpp | output | 2 | M-mode previous-privilege field |
| spp | output | 1 | S-mode previous-privilege bit |

## Verification
On every cycle the assertions check several properties. No take request follows an interrupt aimed below the current mode or a cleared global enable. A same-mode take implies the level beat the threshold. A next-interrupt hit writes its level into the previous level. Lowering returns clear the threshold and reset the previous-privilege field, and non-lowering returns keep the threshold. Other behaviours need the bench's scenarios: a same-mode level exactly equal to the threshold or the previous level, a higher-mode interrupt passing a large threshold, the precedence rules when writes and returns collide, and returns issued from the wrong mode. The cycle-by-cycle model exposes these by comparing every output after mixed random traffic.

// File: rtl/itg_pkg.sv
package itg_pkg;
  typedef enum logic [1:0] {
    PRV_U   = 2'b00,
    PRV_S   = 2'b01,
    PRV_RSV = 2'b10,
    PRV_M   = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    SEL_THR = 2'b00,
    SEL_PIL = 2'b01,
    SEL_PP  = 2'b10,
    SEL_NONE = 2'b11
  } csr_sel_e;

  localparam int NMODES = 2;
  localparam int MODE_S = 0;
  localparam int MODE_M = 1;

  function automatic logic owns_thresh(input logic [1:0] p);
    return (p == PRV_M) || (p == PRV_S);
  endfunction

  function automatic logic mode_idx(input logic [1:0] p);
    return (p == PRV_M);
  endfunction
endpackage

// File: rtl/itg_ret_ctl.sv
module itg_ret_ctl
  import itg_pkg::*;
(
  input  logic [1:0]        cur_priv,
  input  logic              ret_valid,
  input  logic              ret_mret,
  input  logic [1:0]        mpp_q,
  input  logic              spp_q,
  output logic [NMODES-1:0] thr_clr,
  output logic              mpp_rst,
  output logic              spp_rst
);
  logic mret_ok;
  logic sret_ok;

  always_comb begin
    mret_ok = ret_valid && ret_mret && (cur_priv == PRV_M);
    sret_ok = ret_valid && !ret_mret && (cur_priv == PRV_S);
    thr_clr = '0;
    // leaving M for a lower mode, or S for U
    thr_clr[MODE_M] = mret_ok && (mpp_q != PRV_M);
    thr_clr[MODE_S] = sret_ok && !spp_q;
    mpp_rst = mret_ok;
    spp_rst = sret_ok;
  end
endmodule

// File: rtl/itg_state.sv
module itg_state
  import itg_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          csr_we,
  input  logic [1:0]                    csr_sel,
  input  logic                          csr_mode,
  input  logic [LVL_W-1:0]              csr_wdata,
  input  logic [NMODES-1:0]             thr_clr,
  input  logic [NMODES-1:0]             pil_upd,
  input  logic [LVL_W-1:0]              pil_upd_val,
  input  logic                          mpp_rst,
  input  logic                          spp_rst,
  output logic [NMODES-1:0][LVL_W-1:0]  thr_q,
  output logic [NMODES-1:0][LVL_W-1:0]  pil_q,
  output logic [1:0]                    mpp_q,
  output logic                          spp_q
);
  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    logic             hit;
    logic             thr_en;
    logic             pil_en;
    logic [LVL_W-1:0] thr_d;
    logic [LVL_W-1:0] pil_d;
    logic [LVL_W-1:0] thr_r;
    logic [LVL_W-1:0] pil_r;

    assign hit = csr_we && (csr_mode == (m == MODE_M));

    always_comb begin
      thr_en = thr_clr[m] || (hit && (csr_sel == SEL_THR));
      thr_d  = thr_clr[m] ? '0 : csr_wdata;
      pil_en = pil_upd[m] || (hit && (csr_sel == SEL_PIL));
      pil_d  = pil_upd[m] ? pil_upd_val : csr_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_r <= '0;
      end else if (thr_en) begin
        thr_r <= thr_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pil_r <= '0;
      end else if (pil_en) begin
        pil_r <= pil_d;
      end
    end

    assign thr_q[m] = thr_r;
    assign pil_q[m] = pil_r;
  end

  logic       pp_wr;
  logic       mpp_en;
  logic       spp_en;
  logic [1:0] mpp_d;
  logic       spp_d;

  always_comb begin
    pp_wr  = csr_we && (csr_sel == SEL_PP);
    mpp_en = mpp_rst || (pp_wr && csr_mode);
    spp_en = spp_rst || (pp_wr && !csr_mode);
    if (mpp_rst) begin
      mpp_d = PRV_U;
    end else if (csr_wdata[1:0] == PRV_RSV) begin
      mpp_d = PRV_U;
    end else begin
      mpp_d = csr_wdata[1:0];
    end
    spp_d = spp_rst ? 1'b0 : csr_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpp_q <= PRV_U;
    end else if (mpp_en) begin
      mpp_q <= mpp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spp_q <= 1'b0;
    end else if (spp_en) begin
      spp_q <= spp_d;
    end
  end
endmodule

// File: rtl/itg_eval.sv
module itg_eval
  import itg_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic [1:0]                   cur_priv,
  input  logic                         gie_m,
  input  logic                         gie_s,
  input  logic                         irq_valid,
  input  logic [1:0]                   irq_priv,
  input  logic [LVL_W-1:0]             irq_level,
  input  logic                         nxt_rd,
  input  logic [NMODES-1:0][LVL_W-1:0] thr_q,
  input  logic [NMODES-1:0][LVL_W-1:0] pil_q,
  output logic                         take_d,
  output logic                         nxt_hit,
  output logic [NMODES-1:0]            pil_upd
);
  logic [NMODES-1:0] gie;
  logic              tgt_idx;
  logic              cur_idx;
  logic              higher;
  logic              same;
  logic              over_thr;
  logic              over_pil;

  always_comb begin
    gie            = '0;
    gie[MODE_M]    = gie_m;
    gie[MODE_S]    = gie_s;
    tgt_idx        = mode_idx(irq_priv);
    cur_idx        = mode_idx(cur_priv);
    higher         = irq_priv > cur_priv;
    same           = irq_priv == cur_priv;
    over_thr       = irq_level > thr_q[cur_idx];
    over_pil       = irq_level > pil_q[cur_idx];

    take_d = irq_valid && owns_thresh(irq_priv) && gie[tgt_idx] &&
             (higher || (same && over_thr));

    nxt_hit = nxt_rd && irq_valid && same && owns_thresh(cur_priv) &&
              over_thr && over_pil;

    pil_upd = '0;
    pil_upd[cur_idx] = nxt_hit;
  end
endmodule

// File: rtl/irq_thresh_gate.sv
module irq_thresh_gate
  import itg_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int ID_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cur_priv,
  input  logic             gie_m,
  input  logic             gie_s,
  input  logic             irq_valid,
  input  logic [1:0]       irq_priv,
  input  logic [LVL_W-1:0] irq_level,
  input  logic [ID_W-1:0]  irq_id,
  input  logic             csr_we,
  input  logic [1:0]       csr_sel,
  input  logic             csr_mode,
  input  logic [LVL_W-1:0] csr_wdata,
  input  logic             ret_valid,
  input  logic             ret_mret,
  input  logic             nxt_rd,
  output logic             take_req,
  output logic [ID_W-1:0]  take_id,
  output logic             nxt_valid,
  output logic [ID_W-1:0]  nxt_id,
  output logic [LVL_W-1:0] thresh_m,
  output logic [LVL_W-1:0] thresh_s,
  output logic [LVL_W-1:0] pil_m,
  output logic [LVL_W-1:0] pil_s,
  output logic [1:0]       mpp,
  output logic             spp
);
  logic [NMODES-1:0][LVL_W-1:0] thr_q;
  logic [NMODES-1:0][LVL_W-1:0] pil_q;
  logic [NMODES-1:0]            thr_clr;
  logic [NMODES-1:0]            pil_upd;
  logic                         mpp_rst;
  logic                         spp_rst;
  logic [1:0]                   mpp_q;
  logic                         spp_q;
  logic                         take_d;
  logic                         nxt_hit;

  itg_ret_ctl u_ret (
    .cur_priv (cur_priv),
    .ret_valid(ret_valid),
    .ret_mret (ret_mret),
    .mpp_q    (mpp_q),
    .spp_q    (spp_q),
    .thr_clr  (thr_clr),
    .mpp_rst  (mpp_rst),
    .spp_rst  (spp_rst)
  );

  itg_state #(.LVL_W(LVL_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_we     (csr_we),
    .csr_sel    (csr_sel),
    .csr_mode   (csr_mode),
    .csr_wdata  (csr_wdata),
    .thr_clr    (thr_clr),
    .pil_upd    (pil_upd),
    .pil_upd_val(irq_level),
    .mpp_rst    (mpp_rst),
    .spp_rst    (spp_rst),
    .thr_q      (thr_q),
    .pil_q      (pil_q),
    .mpp_q      (mpp_q),
    .spp_q      (spp_q)
  );

  itg_eval #(.LVL_W(LVL_W)) u_eval (
    .cur_priv (cur_priv),
    .gie_m    (gie_m),
    .gie_s    (gie_s),
    .irq_valid(irq_valid),
    .irq_priv (irq_priv),
    .irq_level(irq_level),
    .nxt_rd   (nxt_rd),
    .thr_q    (thr_q),
    .pil_q    (pil_q),
    .take_d   (take_d),
    .nxt_hit  (nxt_hit),
    .pil_upd  (pil_upd)
  );

  // registered take request
  logic            take_n;
  logic [ID_W-1:0] tid_n;
  logic            take_q;
  logic [ID_W-1:0] tid_q;

  always_comb begin
    take_n = take_d;
    tid_n  = take_d ? irq_id : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      tid_q  <= '0;
    end else begin
      take_q <= take_n;
      tid_q  <= tid_n;
    end
  end

  assign take_req  = take_q;
  assign take_id   = tid_q;
  assign nxt_valid = nxt_hit;
  assign nxt_id    = nxt_hit ? irq_id : '0;
  assign thresh_m  = thr_q[MODE_M];
  assign thresh_s  = thr_q[MODE_S];
  assign pil_m     = pil_q[MODE_M];
  assign pil_s     = pil_q[MODE_S];
  assign mpp       = mpp_q;
  assign spp       = spp_q;
endmodule

// File: rtl/itg_chk.sv
module itg_chk #(
  parameter int LVL_W = 8,
  parameter int ID_W  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cur_priv,
  input logic             gie_m,
  input logic             gie_s,
  input logic             irq_valid,
  input logic [1:0]       irq_priv,
  input logic [LVL_W-1:0] irq_level,
  input logic             csr_we,
  input logic             ret_valid,
  input logic             ret_mret,
  input logic             nxt_rd,
  input logic             take_req,
  input logic             nxt_valid,
  input logic [LVL_W-1:0] thresh_m,
  input logic [LVL_W-1:0] thresh_s,
  input logic [LVL_W-1:0] pil_m,
  input logic [LVL_W-1:0] pil_s,
  input logic [1:0]       mpp,
  input logic             spp
);
  p_lower_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |-> ($past(irq_valid) && ($past(irq_priv) >= $past(cur_priv)) &&
                  ($past(irq_priv) != 2'b00) && ($past(irq_priv) != 2'b10)));

  p_same_mode_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && $past(irq_priv == cur_priv)) |->
      ($past(irq_level) > $past(cur_priv == 2'b11 ? thresh_m : thresh_s)));

  p_gie_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |-> $past(irq_priv == 2'b11 ? gie_m : gie_s));

  p_nxt_same_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_valid |-> (nxt_rd && irq_valid && (irq_priv == cur_priv)));

  p_pil_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_valid |=> (($past(cur_priv) == 2'b11 ? pil_m : pil_s) == $past(irq_level)));

  p_mret_lower_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_mret && cur_priv == 2'b11 && mpp != 2'b11) |=>
      (thresh_m == '0 && mpp == 2'b00));

  p_sret_lower_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_mret && cur_priv == 2'b01 && !spp) |=>
      (thresh_s == '0 && !spp));

  p_keep_thr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_mret && cur_priv == 2'b11 && mpp == 2'b11 && !csr_we) |=>
      $stable(thresh_m));
endmodule

bind irq_thresh_gate itg_chk #(.LVL_W(LVL_W), .ID_W(ID_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cur_priv (cur_priv),
  .gie_m    (gie_m),
  .gie_s    (gie_s),
  .irq_valid(irq_valid),
  .irq_priv (irq_priv),
  .irq_level(irq_level),
  .csr_we   (csr_we),
  .ret_valid(ret_valid),
  .ret_mret (ret_mret),
  .nxt_rd   (nxt_rd),
  .take_req (take_req),
  .nxt_valid(nxt_valid),
  .thresh_m (thresh_m),
  .thresh_s (thresh_s),
  .pil_m    (pil_m),
  .pil_s    (pil_s),
  .mpp      (mpp),
  .spp      (spp)
);

// File: tb/tb_irq_thresh_gate.sv
`timescale 1ns/1ps
module tb_irq_thresh_gate;
  localparam int LW = 8;
  localparam int IW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cur_priv;
  logic          gie_m, gie_s;
  logic          irq_valid;
  logic [1:0]    irq_priv;
  logic [LW-1:0] irq_level;
  logic [IW-1:0] irq_id;
  logic          csr_we;
  logic [1:0]    csr_sel;
  logic          csr_mode;
  logic [LW-1:0] csr_wdata;
  logic          ret_valid, ret_mret, nxt_rd;
  logic          take_req;
  logic [IW-1:0] take_id;
  logic          nxt_valid;
  logic [IW-1:0] nxt_id;
  logic [LW-1:0] thresh_m, thresh_s, pil_m, pil_s;
  logic [1:0]    mpp;
  logic          spp;

  always #2.5 clk = ~clk;

  irq_thresh_gate #(.LVL_W(LW), .ID_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .cur_priv(cur_priv), .gie_m(gie_m), .gie_s(gie_s),
    .irq_valid(irq_valid), .irq_priv(irq_priv), .irq_level(irq_level), .irq_id(irq_id),
    .csr_we(csr_we), .csr_sel(csr_sel), .csr_mode(csr_mode), .csr_wdata(csr_wdata),
    .ret_valid(ret_valid), .ret_mret(ret_mret), .nxt_rd(nxt_rd),
    .take_req(take_req), .take_id(take_id), .nxt_valid(nxt_valid), .nxt_id(nxt_id),
    .thresh_m(thresh_m), .thresh_s(thresh_s), .pil_m(pil_m), .pil_s(pil_s),
    .mpp(mpp), .spp(spp)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // reference model state: index 1 = M, 0 = S
  int m_thr[2];
  int m_pil[2];
  int m_mpp;
  int m_spp;
  int m_take;
  int m_tid;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    gie_m = 1; gie_s = 1; irq_valid = 0; irq_priv = 0; irq_level = 0; irq_id = 0;
    csr_we = 0; csr_sel = 0; csr_mode = 0; csr_wdata = 0;
    ret_valid = 0; ret_mret = 0; nxt_rd = 0;
  endtask

  task automatic check_regs(input string tag);
    chk(tag, "take_req", take_req, m_take);
    chk(tag, "take_id",  take_id,  m_tid);
    chk(tag, "thresh_m", thresh_m, m_thr[1]);
    chk(tag, "thresh_s", thresh_s, m_thr[0]);
    chk(tag, "pil_m",    pil_m,    m_pil[1]);
    chk(tag, "pil_s",    pil_s,    m_pil[0]);
    chk(tag, "mpp",      mpp,      m_mpp);
    chk(tag, "spp",      spp,      m_spp);
  endtask

  // one clock: inputs already driven after a falling edge
  task automatic tick(input string tag);
    int cp, ip, lvl, ci, ti, ev, tk;
    int nt[2];
    int np[2];
    int nm, ns;
    #1;
    cp = cur_priv; ip = irq_priv; lvl = irq_level;
    ci = (cp == 3) ? 1 : 0;
    ti = (ip == 3) ? 1 : 0;
    ev = (nxt_rd && irq_valid && ip == cp && (cp == 3 || cp == 1) &&
          lvl > m_pil[ci] && lvl > m_thr[ci]) ? 1 : 0;
    chk(tag, "nxt_valid", nxt_valid, ev);
    chk(tag, "nxt_id", nxt_id, ev ? int'(irq_id) : 0);
    tk = 0;
    if (irq_valid && (ip == 3 || ip == 1) && (ti ? gie_m : gie_s)) begin
      if (ip > cp) tk = 1;
      else if (ip == cp && lvl > m_thr[ti]) tk = 1;
    end
    nt = m_thr; np = m_pil; nm = m_mpp; ns = m_spp;
    if (csr_we) begin
      case (csr_sel)
        2'd0: nt[csr_mode] = csr_wdata;
        2'd1: np[csr_mode] = csr_wdata;
        2'd2: if (csr_mode) nm = (csr_wdata[1:0] == 2'b10) ? 0 : csr_wdata[1:0];
              else ns = csr_wdata[0];
        default: ;
      endcase
    end
    if (ev) np[ci] = lvl;
    if (ret_valid && ret_mret && cp == 3) begin
      if (m_mpp != 3) nt[1] = 0;
      nm = 0;
    end
    if (ret_valid && !ret_mret && cp == 1) begin
      if (m_spp == 0) nt[0] = 0;
      ns = 0;
    end
    @(posedge clk);
    @(negedge clk);
    m_thr = nt; m_pil = np; m_mpp = nm; m_spp = ns;
    m_take = tk; m_tid = tk ? int'(irq_id) : 0;
    check_regs(tag);
  endtask

  task automatic csr_write(input int sel, input bit mode, input int data, input string tag);
    idle();
    csr_we = 1; csr_sel = sel[1:0]; csr_mode = mode; csr_wdata = data[LW-1:0];
    tick(tag);
    idle();
  endtask

  task automatic irq(input int cp, input int ip, input int lvl, input int id);
    cur_priv = cp[1:0]; irq_valid = 1; irq_priv = ip[1:0];
    irq_level = lvl[LW-1:0]; irq_id = id[IW-1:0];
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    cur_priv = 2'b11;
    rst_n = 0;
    m_thr = '{0, 0}; m_pil = '{0, 0}; m_mpp = 0; m_spp = 0; m_take = 0; m_tid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check_regs("R1");
    chk("R1", "nxt_valid", nxt_valid, 0);
    chk("R1", "nxt_id", nxt_id, 0);

    // R11: program M threshold
    cur_priv = 2'b11;
    csr_write(0, 1, 8'h40, "R11");

    // R3: M interrupt from U taken although threshold is 0x40
    idle(); irq(0, 3, 8'h10, 10'h011); tick("R3");
    idle(); cur_priv = 0; tick("R3");

    // R4: same-mode compare against threshold
    idle(); irq(3, 3, 8'h10, 10'h012); tick("R4");
    idle(); irq(3, 3, 8'h40, 10'h013); tick("R4");
    idle(); irq(3, 3, 8'h41, 10'h014); tick("R4");
    idle(); cur_priv = 3; tick("R4");

    // R5: global enable clear blocks
    idle(); irq(0, 3, 8'hff, 10'h015); gie_m = 0; tick("R5");
    idle(); irq(0, 1, 8'hff, 10'h016); gie_s = 0; tick("R5");
    idle(); cur_priv = 0; tick("R5");

    // R2: lower target, U target, reserved target
    idle(); irq(3, 1, 8'hff, 10'h017); tick("R2");
    idle(); irq(0, 0, 8'hff, 10'h018); tick("R2");
    idle(); irq(1, 2, 8'hff, 10'h019); tick("R2");
    idle(); cur_priv = 1; tick("R2");

    // R6 / R7: next-interrupt read
    idle(); irq(3, 3, 8'h50, 10'h01a); nxt_rd = 1; tick("R6");
    idle(); irq(3, 3, 8'h50, 10'h01b); nxt_rd = 1; tick("R6");
    idle(); irq(3, 3, 8'h30, 10'h01c); nxt_rd = 1; tick("R6");
    idle(); irq(0, 3, 8'h60, 10'h01d); nxt_rd = 1; tick("R6");
    idle(); irq(3, 3, 8'h60, 10'h01e); nxt_rd = 1;
    csr_we = 1; csr_sel = 1; csr_mode = 1; csr_wdata = 8'h05; tick("R7");
    idle(); cur_priv = 3; tick("R7");

    // R10: MRET back to M keeps threshold; R8: mpp reset to U
    cur_priv = 3;
    csr_write(2, 1, 3, "R11");
    idle(); cur_priv = 3; ret_valid = 1; ret_mret = 1; tick("R10");
    idle(); cur_priv = 3; ret_valid = 1; ret_mret = 1; tick("R8");
    // R11: clear beats same-cycle threshold write
    csr_write(0, 1, 8'h33, "R11");
    idle(); cur_priv = 3; ret_valid = 1; ret_mret = 1;
    csr_we = 1; csr_sel = 0; csr_mode = 1; csr_wdata = 8'h77; tick("R11");
    // R11: reserved mpp value stored as U; pp reset beats pp write
    csr_write(2, 1, 2, "R11");
    idle(); cur_priv = 3; ret_valid = 1; ret_mret = 1;
    csr_we = 1; csr_sel = 2; csr_mode = 1; csr_wdata = 3; tick("R11");

    // R9: SRET
    cur_priv = 1;
    csr_write(0, 0, 8'h22, "R11");
    csr_write(2, 0, 1, "R11");
    idle(); cur_priv = 1; ret_valid = 1; ret_mret = 0; tick("R10");
    idle(); cur_priv = 1; ret_valid = 1; ret_mret = 0; tick("R9");

    // R12: returns from the wrong mode
    csr_write(0, 1, 8'h44, "R11");
    csr_write(0, 0, 8'h55, "R11");
    idle(); cur_priv = 1; ret_valid = 1; ret_mret = 1; tick("R12");
    idle(); cur_priv = 0; ret_valid = 1; ret_mret = 0; tick("R12");
    idle(); cur_priv = 3; ret_valid = 1; ret_mret = 0; tick("R12");

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      idle();
      r = $urandom_range(0, 2);
      cur_priv = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
      gie_m = ($urandom_range(0, 7) != 0);
      gie_s = ($urandom_range(0, 7) != 0);
      irq_valid = ($urandom_range(0, 3) != 0);
      irq_priv = 2'($urandom_range(0, 3));
      irq_level = 8'($urandom_range(0, 15) * 16 + $urandom_range(0, 2));
      irq_id = 10'($urandom_range(1, 1023));
      nxt_rd = ($urandom_range(0, 2) == 0);
      csr_we = ($urandom_range(0, 3) == 0);
      csr_sel = 2'($urandom_range(0, 3));
      csr_mode = 1'($urandom_range(0, 1));
      csr_wdata = 8'($urandom_range(0, 15) * 16 + $urandom_range(0, 3));
      ret_valid = ($urandom_range(0, 5) == 0);
      ret_mret = 1'($urandom_range(0, 1));
      tick("R4");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule